// File: doc/BRIEF.md
# Half-Cycle Bus Cycle Sequencer

This block drives the control strobes of an 8-bit microprocessor bus at half-clock resolution. Each clock edge of the block's own clock advances one half of a bus clock period. A requester picks a machine-cycle kind, gives an address and write data, and pulses a start strobe. The block then plays the strobe pattern for that kind: a lead-in, an optional stretch of wait states, and a closing phase. The supported kinds are opcode fetch with refresh, memory read, memory write, port input, port output, bus grant and internal (idle) cycles. At the end of a cycle it pulses a done flag and, for reading kinds, returns the byte captured from the data bus.

The controller is a five-state machine. IDLE waits for a start. LEAD plays three fixed half-steps (high, low, high). BODY is the low half in which the wait input is sampled. STALL is the high half of an inserted wait clock. TAIL plays the closing half-steps: two for most kinds, four for the fetch (one data half-step plus the refresh). The transitions are: IDLE to LEAD on start; LEAD to LEAD until its third step, then to BODY; BODY to STALL when waiting is requested and the kind honours it, else to TAIL; STALL always back to BODY; TAIL to TAIL until its last step, then to LEAD if a new start is present, else to IDLE. Every output is decoded from the registered state alone.

A packed 10-bit word reports all lines for the current half-step. Its bit order is fixed because consumers decode it: bit 0 clock-high, 1 memory request, 2 port request, 3 read, 4 write, 5 refresh, 6 first-cycle marker, 7 bus grant, 8 data valid, 9 address valid. The individual strobes are also brought out as separate active-high ports.

Top module: `cpu_bus_cycle_gen`

## Requirements
- R1: While reset is held, and in IDLE after it, the line word is zero, done is low and the returned read byte is zero; a start strobe held during reset has no effect.
- R2: The line word uses bit 0 clock-high, 1 memory request, 2 port request, 3 read, 4 write, 5 refresh, 6 first-cycle marker, 7 bus grant, 8 data valid, 9 address valid; the separate strobe ports equal bits 1 to 7. Within a cycle clock-high alternates, starting high on the first half-step. Read and write are never both set.
- R3: Kind code 0 (fetch), in instant mode (mode input low), plays: clock only; marker+mreq+addr; clock+marker+mreq+read+addr; then marker+mreq+read+addr low half; then clock+marker+mreq+read+addr+data.
- R4: In window mode (mode input high), fetch half-step 0 adds marker and address valid and half-step 1 adds read. No other kind's pattern changes with the mode.
- R5: The fetch ends with four refresh half-steps: refresh+addr, clock+refresh+mreq+addr, refresh+addr; mreq appears only in the clock-high ones. The first of these four is the data half-step of R3.
- R6: Kind code 1 (memory read) plays clock+addr, then mreq+read+addr for the next three half-steps (with the clock bit on the high one), then clock+mreq+read+addr+data, then an all-zero final half-step.
- R7: Kind code 2 (memory write) raises mreq with data valid one half-step after the start. The write strobe first appears on the low half-step of the following clock and is held until the all-zero final half-step.
- R8: Kind codes 3 (port input) and 4 (port output) show only address valid (plus data valid for output) on half-step 1. The port request rises together with read or write on half-step 2, a clock-high half. Port and memory requests are never both set.
- R9: Kind code 5 (bus grant) shows the grant bit on all six half-steps. Kind codes 6 and 7 (internal) only toggle the clock bit. The wait input has no effect on either.
- R10: For kinds 0 to 4, the wait input is sampled at the BODY low half-step. Each asserted sample inserts one full clock that repeats the held strobes (clock-high then low), and then samples again.
- R11: Fetch, memory read and port input load the returned read byte from the data-bus input on their last half-step with read set. All other kinds leave it unchanged.
- R12: Done is high for exactly the final half-step of each cycle. A start present during that half-step begins the next cycle on the following half-step with no idle step between.
- R13: The address and write data are latched when a start is accepted and driven out for the whole cycle. A start strobe seen in the middle of a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-step clock; one edge per bus half-cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Start strobe, accepted in IDLE or on a final half-step |
| cyc_kind | input | 3 | Machine-cycle kind code (0 fetch .. 5 bus grant, 6/7 internal) |
| cyc_addr | input | ADDR_W | Address for the requested cycle |
| cyc_wdata | input | DATA_W | Byte to write for write and output kinds |
| wait_req | input | 1 | Wait request, sampled in BODY |
| window_mode | input | 1 | Static sampling mode: 0 instant, 1 window |
| bus_din | input | DATA_W | Data-bus input for reading kinds |
| bus_addr | output | ADDR_W | Latched address of the current cycle |
| bus_dout | output | DATA_W | Latched write byte of the current cycle |
| mreq | output | 1 | Memory request strobe |
| ioreq | output | 1 | Port request strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| rfsh | output | 1 | Refresh strobe |
| m1 | output | 1 | First-cycle (opcode fetch) marker |
| busack | output | 1 | Bus grant flag |
| cyc_done | output | 1 | High on the final half-step of a cycle |
| rd_data | output | DATA_W | Byte captured by the last reading cycle |
| line_word | output | 10 | Packed line state of the current half-step |

## Verification
The hardest situation to reach from the ports is a run of wait states that ends at an exact sample point. The wait input is looked at only in the BODY low half, and every inserted clock moves the next sample two half-steps later. The driver raises the wait input together with the start. It then counts edges from the accepted start and drops the input just after the last sample that must see it high, so the expected stretch of repeated strobes is known exactly. The same counting places a stray start strobe in the middle of a cycle and a back-to-back start in a final half-step.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int LINE_W = 10;
    typedef logic [LINE_W-1:0] line_t;

    // bit positions of the packed line word (decoded by consumers)
    localparam int B_CLK   = 0;
    localparam int B_MREQ  = 1;
    localparam int B_IOREQ = 2;
    localparam int B_RD    = 3;
    localparam int B_WR    = 4;
    localparam int B_RFSH  = 5;
    localparam int B_M1    = 6;
    localparam int B_BACK  = 7;
    localparam int B_DAT   = 8;
    localparam int B_ADR   = 9;

    localparam line_t L_CLK   = line_t'(1) << B_CLK;
    localparam line_t L_MREQ  = line_t'(1) << B_MREQ;
    localparam line_t L_IOREQ = line_t'(1) << B_IOREQ;
    localparam line_t L_RD    = line_t'(1) << B_RD;
    localparam line_t L_WR    = line_t'(1) << B_WR;
    localparam line_t L_RFSH  = line_t'(1) << B_RFSH;
    localparam line_t L_M1    = line_t'(1) << B_M1;
    localparam line_t L_BACK  = line_t'(1) << B_BACK;
    localparam line_t L_DAT   = line_t'(1) << B_DAT;
    localparam line_t L_ADR   = line_t'(1) << B_ADR;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IOIN  = 3'd3,
        K_IOOUT = 3'd4,
        K_BACK  = 3'd5,
        K_NOP   = 3'd6,
        K_NOP2  = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BODY,
        ST_STALL,
        ST_TAIL
    } state_e;

    localparam int    IDX_W           = 2;
    localparam logic [IDX_W-1:0] LEAD_LAST       = 2'd2;
    localparam logic [IDX_W-1:0] TAIL_LAST_FETCH = 2'd3;
    localparam logic [IDX_W-1:0] TAIL_LAST_STD   = 2'd1;

    function automatic logic kind_waits(kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_MWR) ||
               (k == K_IOIN)  || (k == K_IOOUT);
    endfunction

    function automatic logic kind_reads(kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IOIN);
    endfunction

endpackage

// File: rtl/bcg_fsm.sv
module bcg_fsm
    import bcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  kind_e            kind_in,
    input  logic             wait_req,
    output state_e           state,
    output logic [IDX_W-1:0] idx,
    output kind_e            kind,
    output logic             last,
    output logic             accept
);

    state_e           nxt_state;
    logic [IDX_W-1:0] nxt_idx;
    logic [IDX_W-1:0] tail_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            kind  <= K_FETCH;
        end else begin
            state <= nxt_state;
            idx   <= nxt_idx;
            if (accept) begin
                kind <= kind_in;
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_idx   = idx;
        accept    = 1'b0;
        last      = 1'b0;
        tail_last = (kind == K_FETCH) ? TAIL_LAST_FETCH : TAIL_LAST_STD;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    accept    = 1'b1;
                    nxt_state = ST_LEAD;
                    nxt_idx   = '0;
                end
            end
            ST_LEAD: begin
                if (idx == LEAD_LAST) begin
                    nxt_state = ST_BODY;
                    nxt_idx   = '0;
                end else begin
                    nxt_idx = IDX_W'(idx + 1'b1);
                end
            end
            ST_BODY: begin
                if (wait_req && kind_waits(kind)) begin
                    nxt_state = ST_STALL;
                end else begin
                    nxt_state = ST_TAIL;
                    nxt_idx   = '0;
                end
            end
            ST_STALL: begin
                nxt_state = ST_BODY;
            end
            ST_TAIL: begin
                if (idx == tail_last) begin
                    last = 1'b1;
                    if (start) begin
                        accept    = 1'b1;
                        nxt_state = ST_LEAD;
                        nxt_idx   = '0;
                    end else begin
                        nxt_state = ST_IDLE;
                        nxt_idx   = '0;
                    end
                end else begin
                    nxt_idx = IDX_W'(idx + 1'b1);
                end
            end
            default: begin
                nxt_state = ST_IDLE;
                nxt_idx   = '0;
            end
        endcase
    end

    // R10: an inserted wait clock always returns to the sampling half
    p_stall_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |=> (state == ST_BODY));

    // R9: grant and internal kinds never enter a wait clock
    p_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY && !kind_waits(kind)) |=> (state == ST_TAIL && idx == '0));

    // R13: the latched kind cannot change mid-cycle
    p_kind_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !last) |=> $stable(kind));

endmodule

// File: rtl/bcg_lines.sv
module bcg_lines
    import bcg_pkg::*;
(
    input  state_e           state,
    input  logic [IDX_W-1:0] idx,
    input  kind_e            kind,
    input  logic             window,
    output line_t            word
);

    line_t held;
    line_t lead_first;
    line_t lead_mid;

    // strobes held through the data part and wait clocks of each kind
    always_comb begin
        unique case (kind)
            K_FETCH: held = L_M1 | L_MREQ | L_RD | L_ADR;
            K_MRD:   held = L_MREQ | L_RD | L_ADR;
            K_MWR:   held = L_MREQ | L_WR | L_ADR | L_DAT;
            K_IOIN:  held = L_IOREQ | L_RD | L_ADR;
            K_IOOUT: held = L_IOREQ | L_WR | L_ADR | L_DAT;
            K_BACK:  held = L_BACK;
            default: held = '0;
        endcase
    end

    // first two lead-in half-steps
    always_comb begin
        unique case (kind)
            K_FETCH: begin
                lead_first = window ? (L_M1 | L_ADR) : '0;
                lead_mid   = window ? (L_M1 | L_MREQ | L_RD | L_ADR)
                                    : (L_M1 | L_MREQ | L_ADR);
            end
            K_MRD: begin
                lead_first = L_ADR;
                lead_mid   = L_MREQ | L_RD | L_ADR;
            end
            K_MWR: begin
                lead_first = L_ADR;
                lead_mid   = L_MREQ | L_ADR | L_DAT;
            end
            K_IOIN: begin
                lead_first = L_ADR;
                lead_mid   = L_ADR;
            end
            K_IOOUT: begin
                lead_first = L_ADR;
                lead_mid   = L_ADR | L_DAT;
            end
            K_BACK: begin
                lead_first = L_BACK;
                lead_mid   = L_BACK;
            end
            default: begin
                lead_first = '0;
                lead_mid   = '0;
            end
        endcase
    end

    // output decode of the registered state
    always_comb begin
        word = '0;
        unique case (state)
            ST_IDLE: word = '0;
            ST_LEAD: begin
                unique case (idx)
                    2'd0:    word = L_CLK | lead_first;
                    2'd1:    word = lead_mid;
                    2'd2:    word = (kind == K_MWR) ? (L_CLK | L_MREQ | L_ADR | L_DAT)
                                                    : (L_CLK | held);
                    default: word = '0;
                endcase
            end
            ST_BODY:  word = held;
            ST_STALL: word = L_CLK | held;
            ST_TAIL: begin
                if (kind == K_FETCH) begin
                    unique case (idx)
                        2'd0:    word = L_CLK | held | L_DAT;
                        2'd2:    word = L_CLK | L_RFSH | L_MREQ | L_ADR;
                        default: word = L_RFSH | L_ADR;
                    endcase
                end else if (idx == 2'd0) begin
                    word = L_CLK | held | (kind_waits(kind) ? L_DAT : '0);
                end else begin
                    word = (kind == K_BACK) ? L_BACK : '0;
                end
            end
            default: word = '0;
        endcase
    end

    // R2: read and write never together
    always_comb begin
        p_rdwr_excl_r2: assert (!(word[B_RD] && word[B_WR]));
    end

    // R8: port and memory requests never together
    always_comb begin
        p_iomem_excl_r8: assert (!(word[B_MREQ] && word[B_IOREQ]));
    end

endmodule

// File: rtl/bcg_capture.sv
module bcg_capture
    import bcg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  state_e            state,
    input  logic [IDX_W-1:0]  idx,
    input  kind_e             kind,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic [DATA_W-1:0] rd_data
);

    logic take_read;
    assign take_read = (state == ST_TAIL) && (idx == '0) && kind_reads(kind);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr <= '0;
            bus_dout <= '0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                bus_addr <= addr_in;
                bus_dout <= wdata_in;
            end
            if (take_read) begin
                rd_data <= bus_din;
            end
        end
    end

    // R11: returned byte only moves on a reading data half-step
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_read |=> $stable(rd_data));

    // R13: latched address steady while a cycle is not being accepted
    p_addr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(bus_addr));

endmodule

// File: rtl/cpu_bus_cycle_gen.sv
module cpu_bus_cycle_gen
    import bcg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [2:0]        cyc_kind,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_wdata,
    input  logic              wait_req,
    input  logic              window_mode,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              mreq,
    output logic              ioreq,
    output logic              rd,
    output logic              wr,
    output logic              rfsh,
    output logic              m1,
    output logic              busack,
    output logic              cyc_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [9:0]        line_word
);

    state_e           st;
    logic [IDX_W-1:0] st_idx;
    kind_e            cur_kind;
    logic             at_last;
    logic             accept;
    line_t            word;

    bcg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .kind_in  (kind_e'(cyc_kind)),
        .wait_req (wait_req),
        .state    (st),
        .idx      (st_idx),
        .kind     (cur_kind),
        .last     (at_last),
        .accept   (accept)
    );

    bcg_lines u_lines (
        .state  (st),
        .idx    (st_idx),
        .kind   (cur_kind),
        .window (window_mode),
        .word   (word)
    );

    bcg_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .addr_in  (cyc_addr),
        .wdata_in (cyc_wdata),
        .state    (st),
        .idx      (st_idx),
        .kind     (cur_kind),
        .bus_din  (bus_din),
        .bus_addr (bus_addr),
        .bus_dout (bus_dout),
        .rd_data  (rd_data)
    );

    assign line_word = word;
    assign mreq      = word[B_MREQ];
    assign ioreq     = word[B_IOREQ];
    assign rd        = word[B_RD];
    assign wr        = word[B_WR];
    assign rfsh      = word[B_RFSH];
    assign m1        = word[B_M1];
    assign busack    = word[B_BACK];
    assign cyc_done  = at_last;

    // R2: a clock-high half-step is always followed by a low one
    p_clk_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_word[B_CLK] |=> !line_word[B_CLK]);

    // R2: a busy non-final low half-step is followed by a high one
    p_clk_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !line_word[B_CLK] && !cyc_done) |=> line_word[B_CLK]);

    // R12: done lasts a single half-step
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    // R5: during refresh, memory request only in clock-high halves
    p_rfsh_mreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh && !line_word[B_CLK]) |-> !mreq);

    // R8: port request rises only on a clock-high half-step
    p_io_onset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ioreq) |-> line_word[B_CLK]);

endmodule

// File: tb/cpu_bus_cycle_gen_bench.sv
`timescale 1ns/1ps
module cpu_bus_cycle_gen_bench;

    localparam logic [9:0] C  = 10'h001, MQ = 10'h002, IQ = 10'h004, RD = 10'h008,
                           WR = 10'h010, RF = 10'h020, M1 = 10'h040, BA = 10'h080,
                           DV = 10'h100, AV = 10'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic [2:0]  cyc_kind = '0;
    logic [15:0] cyc_addr = '0;
    logic [7:0]  cyc_wdata = '0;
    logic        wait_req = 1'b0;
    logic        window_mode = 1'b0;
    logic [7:0]  bus_din = '0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout;
    logic        mreq, ioreq, rd, wr, rfsh, m1, busack, cyc_done;
    logic [7:0]  rd_data;
    logic [9:0]  line_word;

    always #10 clk = ~clk;

    cpu_bus_cycle_gen u_cpu_bus_cycle_gen (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
        .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .wait_req(wait_req),
        .window_mode(window_mode), .bus_din(bus_din), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .mreq(mreq), .ioreq(ioreq), .rd(rd), .wr(wr),
        .rfsh(rfsh), .m1(m1), .busack(busack), .cyc_done(cyc_done),
        .rd_data(rd_data), .line_word(line_word)
    );

    typedef struct {
        logic [9:0] w;
        logic       d;
        int         tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails = 0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;
    logic [7:0] exp_rd = '0;

    task automatic chk(input bit ok, input int tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void push(input logic [9:0] w, input logic d, input int tag);
        exp_t e;
        e.w = w; e.d = d; e.tag = tag;
        sb.push_back(e);
    endfunction

    // monitor: one half-step per negedge
    always @(negedge clk) begin
        if (mon_on) begin
            if (sb.size() > 0) begin : pop_blk
                exp_t e;
                e = sb.pop_front();
                chk(line_word == e.w, e.tag, "line word", 32'(line_word), 32'(e.w));
                chk(cyc_done == e.d, 12, "done", 32'(cyc_done), 32'(e.d));
                chk({busack, m1, rfsh, wr, rd, ioreq, mreq} == e.w[7:1], 2, "strobe ports",
                    32'({busack, m1, rfsh, wr, rd, ioreq, mreq}), 32'(e.w[7:1]));
            end else begin
                // R12: quiet between cycles
                chk(line_word == 10'h000 && !cyc_done, 12, "idle lines",
                    32'(line_word), 32'h0);
            end
        end
    end

    // expected half-step list built from the requirements
    task automatic exp_cycle(input logic [2:0] k, input bit win, input int nw);
        logic [9:0] s;
        int tag;
        int ew;
        bit waits;
        waits = (k <= 3'd4);
        ew = waits ? nw : 0;
        case (k)
            3'd0: begin s = M1 | MQ | RD | AV; tag = 3; end
            3'd1: begin s = MQ | RD | AV;      tag = 6; end
            3'd2: begin s = MQ | WR | AV | DV; tag = 7; end
            3'd3: begin s = IQ | RD | AV;      tag = 8; end
            3'd4: begin s = IQ | WR | AV | DV; tag = 8; end
            3'd5: begin s = BA;                tag = 9; end
            default: begin s = 10'h000;        tag = 9; end
        endcase
        // lead-in
        case (k)
            3'd0: begin
                push(win ? (C | M1 | AV) : C, 1'b0, win ? 4 : 3);
                push(win ? (M1 | MQ | RD | AV) : (M1 | MQ | AV), 1'b0, win ? 4 : 3);
            end
            3'd1: begin push(C | AV, 1'b0, 6); push(MQ | RD | AV, 1'b0, 6); end
            3'd2: begin push(C | AV, 1'b0, 7); push(MQ | AV | DV, 1'b0, 7); end
            3'd3: begin push(C | AV, 1'b0, 8); push(AV, 1'b0, 8); end
            3'd4: begin push(C | AV, 1'b0, 8); push(AV | DV, 1'b0, 8); end
            3'd5: begin push(C | BA, 1'b0, 9); push(BA, 1'b0, 9); end
            default: begin push(C, 1'b0, 9); push(10'h000, 1'b0, 9); end
        endcase
        push((k == 3'd2) ? (C | MQ | AV | DV) : (C | s), 1'b0, tag);
        push(s, 1'b0, tag);
        for (int i = 0; i < ew; i++) begin
            push(C | s, 1'b0, 10);
            push(s, 1'b0, 10);
        end
        if (k == 3'd0) begin
            push(C | s | DV, 1'b0, 3);
            push(RF | AV, 1'b0, 5);
            push(C | RF | MQ | AV, 1'b0, 5);
            push(RF | AV, 1'b1, 5);
        end else begin
            push(C | s | (waits ? DV : 10'h000), 1'b0, tag);
            push((k == 3'd5) ? BA : 10'h000, 1'b1, tag);
        end
    endtask

    // driver: issues one cycle and returns in its final half-step
    task automatic run_cycle(input logic [2:0] k, input bit win, input int nw,
                             input logic [15:0] a, input logic [7:0] wd,
                             input logic [7:0] din, input bit poke);
        int len;
        len = ((k == 3'd0) ? 8 : 6) + ((k <= 3'd4) ? 2 * nw : 0);
        @(negedge clk);
        #2;
        cyc_kind = k; window_mode = win; cyc_addr = a; cyc_wdata = wd;
        bus_din = din; wait_req = (nw > 0); cyc_start = 1'b1;
        exp_cycle(k, win, nw);
        @(posedge clk);
        #2;
        cyc_start = 1'b0;
        for (int s = 1; s <= len - 1; s++) begin
            @(posedge clk);
            #2;
            if (nw > 0 && s == 2 * nw + 2) wait_req = 1'b0;
            if (poke && s == 2) begin
                // R13: stray start mid-cycle
                cyc_start = 1'b1; cyc_kind = 3'd2; cyc_addr = ~a; cyc_wdata = ~wd;
            end
            if (s == 3) begin
                cyc_start = 1'b0;
                chk(bus_addr == a, 13, "latched address", 32'(bus_addr), 32'(a));
                chk(bus_dout == wd, 13, "latched write byte", 32'(bus_dout), 32'(wd));
            end
        end
        wait_req = 1'b0;
        if (k == 3'd0 || k == 3'd1 || k == 3'd3) exp_rd = din;
        // R11: returned byte after the read half-step, or unchanged
        chk(rd_data == exp_rd, 11, "read byte", 32'(rd_data), 32'(exp_rd));
    endtask

    initial begin
        // R1: reset state, start held during reset
        cyc_start = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(line_word == 10'h000, 1, "reset lines", 32'(line_word), 32'h0);
        chk(cyc_done == 1'b0, 1, "reset done", 32'(cyc_done), 32'h0);
        chk(rd_data == 8'h00, 1, "reset read byte", 32'(rd_data), 32'h0);
        #2;
        cyc_start = 1'b0;
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (2) @(posedge clk);

        run_cycle(3'd0, 1'b0, 0, 16'h1234, 8'h00, 8'h3E, 1'b0); // R3 R5 fetch instant
        run_cycle(3'd0, 1'b1, 0, 16'h1235, 8'h00, 8'hC9, 1'b0); // R4 fetch window
        run_cycle(3'd0, 1'b0, 2, 16'h2000, 8'h00, 8'h77, 1'b0); // R10 fetch with waits
        repeat (3) @(posedge clk);
        run_cycle(3'd1, 1'b0, 0, 16'h4000, 8'h00, 8'hA5, 1'b0); // R6 read
        run_cycle(3'd1, 1'b1, 1, 16'h4001, 8'h00, 8'h5A, 1'b0); // R4 R10 read, window ignored
        run_cycle(3'd2, 1'b0, 0, 16'h8000, 8'h42, 8'hFF, 1'b0); // R7 write, R11 unchanged
        run_cycle(3'd2, 1'b0, 3, 16'h8001, 8'h24, 8'h00, 1'b0); // R7 R10 write with waits
        repeat (2) @(posedge clk);
        run_cycle(3'd3, 1'b0, 0, 16'h00FE, 8'h00, 8'h81, 1'b0); // R8 input
        run_cycle(3'd3, 1'b0, 1, 16'h01FE, 8'h00, 8'h18, 1'b0); // R8 R10 input with wait
        run_cycle(3'd4, 1'b1, 0, 16'h00FF, 8'h99, 8'h00, 1'b0); // R8 output
        run_cycle(3'd5, 1'b0, 2, 16'h0000, 8'h00, 8'h11, 1'b0); // R9 grant, wait ignored
        run_cycle(3'd6, 1'b0, 2, 16'h0000, 8'h00, 8'h22, 1'b0); // R9 internal, wait ignored
        run_cycle(3'd7, 1'b1, 0, 16'h0000, 8'h00, 8'h33, 1'b0); // R9 spare code internal
        run_cycle(3'd1, 1'b0, 0, 16'hBEEF, 8'h6C, 8'hD2, 1'b1); // R13 stray start ignored
        repeat (4) @(posedge clk);
        @(negedge clk);
        #2;
        chk(sb.size() == 0, 12, "scoreboard drained", 32'(sb.size()), 32'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R12 watchdog actual=%0h expected=%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule